// File: doc/BRIEF.md
# CPU Control Dispatch Register

This block is a write-only command register that lets software steer other processors. Each write carries a command type, a target CPU number and a 6-bit vector. The block decodes an accepted write into one single-cycle strobe aimed at the target CPU. The four commands are: post an interrupt, apply a power-on reset, halt, and resume. The interrupt fabric and the reset sequence sit outside the block and consume these strobes.

The block also keeps a run/halt flag for every CPU. Reset and resume set the target's flag to running, halt clears it, and an interrupt post leaves it unchanged, so a halted CPU stays halted when interrupts arrive. A reset command counts only when its vector equals the power-on-reset code. Any other vector sets a sticky error flag and takes no action. A command whose target number is at or above the configured CPU count is dropped without any effect, and it does not set the error flag.

Top module: `cpu_cmd_dispatch`

## Requirements
- R1: A write with type 0 in bits 17:16 and an in-range target t in bits 12:8 raises bit t of `int_stb` in the cycle after the write, with `int_vec` equal to bits 5:0 of the word. `int_vec` is zero whenever `int_stb` is zero.
- R2: A write with type 1 and a vector equal to `POR_VEC` (default 6'h01) raises bit t of `rst_stb` in the next cycle and sets `run_state[t]` to 1.
- R3: A type 1 write to an in-range target with any other vector raises no strobe, leaves `run_state` unchanged and sets `cmd_err`. `cmd_err` then stays set until reset.
- R4: A type 2 write raises bit t of `halt_stb` in the next cycle and clears `run_state[t]`. A later interrupt post to a halted CPU leaves its `run_state` bit at 0.
- R5: A type 3 write raises bit t of `resume_stb` in the next cycle and sets `run_state[t]` to 1.
- R6: A write whose target is at or above `NCPU` raises no strobe and changes neither `run_state` nor `cmd_err`, whatever its type and vector.
- R7: After reset, `run_state` is 1 for CPU 0 and 0 for all others, no strobe is active, and `cmd_err` is 0.
- R8: Each strobe lasts exactly one cycle. At most one strobe bit is active across all four strobe outputs in any cycle, and no strobe appears in a cycle that does not follow a write.
- R9: Bits of the written word outside 17:16, 12:8 and 5:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write enable |
| wr_data | input | WORD_W | Command word |
| int_stb | output | NCPU | Interrupt post strobe, one bit per CPU |
| int_vec | output | 6 | Vector that goes with `int_stb` |
| rst_stb | output | NCPU | Power-on reset strobe, one bit per CPU |
| halt_stb | output | NCPU | Halt strobe, one bit per CPU |
| resume_stb | output | NCPU | Resume strobe, one bit per CPU |
| run_state | output | NCPU | Per-CPU run flag (1 = running) |
| cmd_err | output | 1 | Sticky flag for a reset command with a wrong vector |

## Verification
Two events can fall in the same cycle: the strobe and run-state update from one command, and the capture of the next command written directly behind it. The bench provokes this by issuing long runs of back-to-back writes without idle cycles, including a halt followed at once by a resume of the same CPU. After each write it judges the strobes, `int_vec`, `run_state` and `cmd_err` against a model that applies each command in order. Idle cycles are also inserted between commands, and the bench checks that every strobe is low in those cycles.

// File: rtl/cpu_cmd_dispatch.sv
module cpu_cmd_dispatch #(
  parameter int          NCPU    = 8,
  parameter int          WORD_W  = 64,
  parameter logic [5:0]  POR_VEC = 6'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [NCPU-1:0]   int_stb,
  output logic [5:0]        int_vec,
  output logic [NCPU-1:0]   rst_stb,
  output logic [NCPU-1:0]   halt_stb,
  output logic [NCPU-1:0]   resume_stb,
  output logic [NCPU-1:0]   run_state,
  output logic              cmd_err
);
  localparam int CPU_W = 5;
  localparam logic [NCPU-1:0] RUN_INIT = NCPU'(1);

  logic [1:0]       cmd_kind;
  logic [CPU_W-1:0] tgt;
  logic [5:0]       vec;
  logic             in_range, go, por_ok;
  logic [NCPU-1:0]  sel;

  assign cmd_kind = wr_data[17:16];
  assign tgt      = wr_data[12:8];
  assign vec      = wr_data[5:0];
  assign in_range = 32'(tgt) < NCPU;
  assign go       = wr_en && in_range;
  assign por_ok   = vec == POR_VEC;

  for (genvar i = 0; i < NCPU; i++) begin : g_sel
    assign sel[i] = go && (tgt == CPU_W'(i));
  end

  logic [NCPU-1:0] int_n, rst_n_stb, halt_n, res_n;
  assign int_n     = (cmd_kind == 2'd0) ? sel : '0;
  assign rst_n_stb = (cmd_kind == 2'd1 && por_ok) ? sel : '0;
  assign halt_n    = (cmd_kind == 2'd2) ? sel : '0;
  assign res_n     = (cmd_kind == 2'd3) ? sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_stb    <= '0;
      int_vec    <= '0;
      rst_stb    <= '0;
      halt_stb   <= '0;
      resume_stb <= '0;
      run_state  <= RUN_INIT;
      cmd_err    <= 1'b0;
    end else begin
      int_stb    <= int_n;
      int_vec    <= (go && cmd_kind == 2'd0) ? vec : 6'd0;
      rst_stb    <= rst_n_stb;
      halt_stb   <= halt_n;
      resume_stb <= res_n;
      run_state  <= (run_state & ~halt_n) | rst_n_stb | res_n;
      if (go && cmd_kind == 2'd1 && !por_ok)
        cmd_err <= 1'b1;
    end
  end
endmodule

module cpu_cmd_dispatch_chk #(
  parameter int NCPU   = 8,
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [NCPU-1:0]   int_stb,
  input logic [5:0]        int_vec,
  input logic [NCPU-1:0]   rst_stb,
  input logic [NCPU-1:0]   halt_stb,
  input logic [NCPU-1:0]   resume_stb,
  input logic [NCPU-1:0]   run_state,
  input logic              cmd_err
);
  logic [4*NCPU-1:0] all_stb;
  assign all_stb = {int_stb, rst_stb, halt_stb, resume_stb};

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_stb));
  a_r8_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> all_stb == '0);
  a_r1_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    int_stb == '0 |-> int_vec == 6'd0);
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
  a_r4_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state & halt_stb) == '0);
  a_r5_resume_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state & resume_stb) == resume_stb);
  a_r2_reset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state & rst_stb) == rst_stb);
  a_r4_int_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[17:16] == 2'd0 |=> $stable(run_state));
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (32'(wr_data[12:8]) >= NCPU) |=>
      all_stb == '0 && $stable(run_state) && $stable(cmd_err));
endmodule

bind cpu_cmd_dispatch cpu_cmd_dispatch_chk #(.NCPU(NCPU), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .int_stb(int_stb), .int_vec(int_vec), .rst_stb(rst_stb),
  .halt_stb(halt_stb), .resume_stb(resume_stb),
  .run_state(run_state), .cmd_err(cmd_err)
);

// File: tb/cpu_cmd_dispatch_tb.sv
module cpu_cmd_dispatch_tb;
  localparam int NCPU = 8;
  localparam int WORD_W = 64;
  localparam logic [5:0] POR = 6'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [WORD_W-1:0] wr_data = '0;
  logic [NCPU-1:0] int_stb, rst_stb, halt_stb, resume_stb, run_state;
  logic [5:0] int_vec;
  logic cmd_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [NCPU-1:0] run_m;
  logic err_m;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_cmd_dispatch #(.NCPU(NCPU), .WORD_W(WORD_W), .POR_VEC(POR)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .int_stb(int_stb), .int_vec(int_vec), .rst_stb(rst_stb),
    .halt_stb(halt_stb), .resume_stb(resume_stb),
    .run_state(run_state), .cmd_err(cmd_err));

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag, logic [NCPU-1:0] ei, logic [5:0] ev,
                           logic [NCPU-1:0] er, logic [NCPU-1:0] eh, logic [NCPU-1:0] es);
    chk(tag, "int_stb", 64'(int_stb), 64'(ei));
    chk(tag, "int_vec", 64'(int_vec), 64'(ev));
    chk(tag, "rst_stb", 64'(rst_stb), 64'(er));
    chk(tag, "halt_stb", 64'(halt_stb), 64'(eh));
    chk(tag, "resume_stb", 64'(resume_stb), 64'(es));
    chk(tag, "run_state", 64'(run_state), 64'(run_m));
    chk(tag, "cmd_err", 64'(cmd_err), 64'(err_m));
  endtask

  // Called at a negedge; leaves wr_en high so a following issue is back-to-back.
  task automatic issue(logic [1:0] ty, int cpu, logic [5:0] vec, logic [63:0] junk);
    logic [63:0] fmask;
    logic [NCPU-1:0] ei, er, eh, es, one;
    logic [5:0] ev;
    string tag;
    fmask = 64'h3_1F3F;
    wr_en = 1'b1;
    wr_data = WORD_W'((junk & ~fmask) | (64'(ty) << 16) | (64'(cpu) << 8) | 64'(vec));
    @(posedge clk);
    @(negedge clk);
    ei = '0; er = '0; eh = '0; es = '0; ev = '0;
    one = (cpu < NCPU) ? NCPU'(1) << cpu : '0;
    if (cpu >= NCPU) tag = "R6";
    else case (ty)
      2'd0: begin tag = "R1/R9"; ei = one; ev = vec; end
      2'd1: if (vec == POR) begin tag = "R2"; er = one; run_m = run_m | one; end
            else begin tag = "R3"; err_m = 1'b1; end
      2'd2: begin tag = "R4"; eh = one; run_m = run_m & ~one; end
      default: begin tag = "R5"; es = one; run_m = run_m | one; end
    endcase
    check_all(tag, ei, ev, er, eh, es);
  endtask

  task automatic idle();
    wr_en = 1'b0;
    wr_data = '0;
    @(posedge clk);
    @(negedge clk);
    check_all("R8 idle", '0, 6'd0, '0, '0, '0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    run_m = NCPU'(1);
    err_m = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R7 reset", '0, 6'd0, '0, '0, '0);
    rst_n = 1'b1;
    idle();
    // R6: bad reset to an absent CPU must not set the error flag
    issue(2'd1, 9, 6'h15, 64'hFFFF_0000_C0C0_0000);
    idle();
    chk("R6", "cmd_err", 64'(cmd_err), 64'd0);
    // R4/R5: halt then resume of the same CPU back-to-back
    issue(2'd2, 0, 6'h00, '0);
    issue(2'd3, 0, 6'h00, '0);
    issue(2'd2, 3, 6'h3F, '1);
    issue(2'd0, 3, 6'h22, '1);
    chk("R4 no wake", "run_state[3]", 64'(run_state[3]), 64'd0);
    idle();
    // Sweep: halt, interrupt, resume, reset over every target number
    for (int p = 0; p < 4; p++) begin
      logic [1:0] ty;
      ty = (p == 0) ? 2'd2 : (p == 1) ? 2'd0 : (p == 2) ? 2'd3 : 2'd1;
      for (int c = 0; c < 32; c++) begin
        for (int v = 0; v < 2; v++) begin
          logic [63:0] junk;
          junk = 64'(c * 7 + v + p * 131) * 64'h9E37_79B9_7F4A_7C15;
          issue(ty, c, (v == 0) ? POR : 6'(c * 5 + 2), junk);
          if (((c + v) % 3) == 0) idle();
        end
      end
      idle();
    end
    chk("R3 sticky", "cmd_err", 64'(cmd_err), 64'd1);
    idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule